// File: doc/BRIEF.md
# Trigger Command Decoder with Tag Table

This block sits behind the command line decoder of a pixel readout chip. Each 16-bit command frame covers four bunch crossings. The block recognises frames that carry triggers. A trigger frame holds a 4-bit crossing pattern and a 5-bit tag chosen by the host. The block turns the pattern into one trigger pulse per selected crossing, timed on the bunch-crossing strobes that follow the frame.

For every pulse, the block forms an extended tag from the host tag and the position of the crossing inside the frame. It stores the current bunch-crossing count in a table entry selected by that extended tag. Downstream readout labels hit data with the extended tag alone. Any consumer can then recover the crossing number through a registered lookup port. Because of this, the local crossing counter never has to be aligned with the counters of other chips.

Top module: `trig_tag_decoder`

## Requirements
- R1: After reset, trig_pulse is 0, every table entry reads back with lk_valid 0, and the crossing counter starts at 0.
- R2: A frame is a trigger frame when frame_valid is 1, frame_data[15:12] equals 4'hB, and the pattern frame_data[11:8] is non-zero. The tag is frame_data[4:0], and frame_data[7:5] is ignored.
- R3: Slot k (k = 0..3) of a trigger frame is served by the (k+1)-th bx_strobe after the frame cycle. Slot k fires when pattern bit 3-k is set. A firing slot raises trig_pulse for exactly the one cycle after its strobe.
- R4: While trig_pulse is high, trig_xtag equals {tag, k}, a 7-bit value made of the tag followed by the 2-bit slot index.
- R5: The crossing counter adds one on every bx_strobe and wraps modulo 256. The value recorded for a pulse is the number of strobes that came before its strobe, modulo 256.
- R6: A firing slot writes the recorded count into table entry trig_xtag and marks that entry valid. In the cycle after lk_xtag is applied, lk_valid and lk_bcid show that entry.
- R7: A frame that is not a trigger frame produces no pulse and leaves the table unchanged. Slots still pending from an earlier trigger frame carry on without change.
- R8: A new trigger frame discards any slots still pending from the previous one and restarts at slot 0.
- R9: When an extended tag is reused, its table entry is overwritten with the newer count.
- R10: trig_pulse is high only in a cycle that directly follows a bx_strobe, and only while slots are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | frame_data holds a new command frame |
| frame_data | input | 16 | Decoded command frame |
| bx_strobe | input | 1 | One-cycle bunch-crossing strobe |
| trig_pulse | output | 1 | Trigger pulse for one crossing |
| trig_xtag | output | 7 | Extended tag of the current pulse |
| lk_xtag | input | 7 | Table lookup address |
| lk_valid | output | 1 | Looked-up entry has been written |
| lk_bcid | output | 8 | Crossing count stored in the looked-up entry |

## Verification
The bench sends all sixteen patterns and checks pulse placement and the extended tag on every strobe.
- A reversed bit order would put pulses on the wrong crossings.
- An off-by-one counter sample would record shifted counts, and this shows up once the count is made to wrap.

Non-trigger frames are sent both on their own and in the middle of a pending expansion. A design that decoded them loosely, or that cleared the pending slots, would produce extra pulses or lose pulses.

Pre-emption by a second trigger frame and reuse of a tag are also covered. A final sweep over all 128 table entries would expose any write that landed on the wrong entry or that failed to overwrite.

// File: rtl/trig_tag_pkg.sv
package trig_tag_pkg;
    localparam int FRAME_W = 16;
    localparam int TAG_W   = 5;
    localparam int SLOT_N  = 4;
    localparam int POS_W   = $clog2(SLOT_N);
    localparam int XTAG_W  = TAG_W + POS_W;
    localparam int DEPTH   = 1 << XTAG_W;
    localparam int BCID_W  = 8;
    localparam logic [3:0] TRIG_MARK = 4'hB;

    typedef struct packed {
        logic              is_trig;
        logic [SLOT_N-1:0] pattern;
        logic [TAG_W-1:0]  tag;
    } trig_cmd_t;

    function automatic trig_cmd_t decode_frame(input logic [FRAME_W-1:0] f);
        trig_cmd_t c;
        c.pattern = f[11:8];
        c.tag     = f[TAG_W-1:0];
        c.is_trig = (f[15:12] == TRIG_MARK) && (f[11:8] != '0);
        return c;
    endfunction
endpackage

// File: rtl/trig_frame_decode.sv
module trig_frame_decode
    import trig_tag_pkg::*;
(
    input  logic               valid,
    input  logic [FRAME_W-1:0] frame,
    output logic               load,
    output trig_cmd_t          cmd
);
    always_comb begin
        cmd  = decode_frame(frame);
        load = valid && cmd.is_trig;
    end
endmodule

// File: rtl/trig_slot_seq.sv
module trig_slot_seq
    import trig_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  trig_cmd_t         cmd,
    input  logic              bx_strobe,
    output logic              pulse,
    output logic [XTAG_W-1:0] pulse_xtag,
    output logic              wr_en,
    output logic [XTAG_W-1:0] wr_xtag,
    output logic [BCID_W-1:0] wr_bcid,
    output logic              active,
    output logic [BCID_W-1:0] bcid
);
    logic [SLOT_N-1:0] pat_q;
    logic [TAG_W-1:0]  tag_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  bit_idx;
    logic              fire;

    always_comb begin
        bit_idx = POS_W'(SLOT_N - 1) - pos_q;
        fire    = active && bx_strobe && pat_q[bit_idx];
        wr_en   = fire;
        wr_xtag = {tag_q, pos_q};
        wr_bcid = bcid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pat_q      <= '0;
            tag_q      <= '0;
            pos_q      <= '0;
            bcid       <= '0;
            pulse      <= 1'b0;
            pulse_xtag <= '0;
        end else begin
            pulse <= fire;
            if (fire) pulse_xtag <= {tag_q, pos_q};
            if (bx_strobe) bcid <= bcid + 1'b1;
            if (active && bx_strobe) begin
                pos_q <= pos_q + 1'b1;
                if (pos_q == POS_W'(SLOT_N - 1)) active <= 1'b0;
            end
            if (load) begin
                active <= 1'b1;
                pos_q  <= '0;
                pat_q  <= cmd.pattern;
                tag_q  <= cmd.tag;
            end
        end
    end
endmodule

// File: rtl/trig_tag_table.sv
module trig_tag_table
    import trig_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [XTAG_W-1:0] waddr,
    input  logic [BCID_W-1:0] wdata,
    input  logic [XTAG_W-1:0] raddr,
    output logic              rd_valid,
    output logic [BCID_W-1:0] rd_bcid
);
    logic [BCID_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  filled;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rd_bcid <= mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filled   <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (we) filled[waddr] <= 1'b1;
            rd_valid <= filled[raddr];
        end
    end
endmodule

// File: rtl/trig_tag_decoder.sv
module trig_tag_decoder
    import trig_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [15:0]       frame_data,
    input  logic              bx_strobe,
    output logic              trig_pulse,
    output logic [XTAG_W-1:0] trig_xtag,
    input  logic [XTAG_W-1:0] lk_xtag,
    output logic              lk_valid,
    output logic [BCID_W-1:0] lk_bcid
);
    trig_cmd_t         cmd;
    logic              load;
    logic              wr_en;
    logic [XTAG_W-1:0] wr_xtag;
    logic [BCID_W-1:0] wr_bcid;
    logic              seq_active;
    logic [BCID_W-1:0] bcid_cnt;

    trig_frame_decode u_dec (
        .valid(frame_valid), .frame(frame_data), .load(load), .cmd(cmd)
    );

    trig_slot_seq u_seq (
        .clk(clk), .rst(rst), .load(load), .cmd(cmd), .bx_strobe(bx_strobe),
        .pulse(trig_pulse), .pulse_xtag(trig_xtag),
        .wr_en(wr_en), .wr_xtag(wr_xtag), .wr_bcid(wr_bcid),
        .active(seq_active), .bcid(bcid_cnt)
    );

    trig_tag_table u_tab (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_xtag), .wdata(wr_bcid),
        .raddr(lk_xtag), .rd_valid(lk_valid), .rd_bcid(lk_bcid)
    );
endmodule

// File: rtl/trig_tag_checker.sv
module trig_tag_checker
    import trig_tag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bx_strobe,
    input logic              trig_pulse,
    input logic              lk_valid,
    input logic              seq_active,
    input logic [BCID_W-1:0] bcid
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!trig_pulse && !lk_valid && bcid == '0));

    assert_pulse_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(bx_strobe));

    assert_pulse_needs_pending_R3: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(seq_active));

    assert_bcid_step_R5: assert property (@(posedge clk) disable iff (rst)
        bx_strobe |=> (bcid == BCID_W'($past(bcid) + 1'b1)));

    assert_bcid_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> $stable(bcid));
endmodule

bind trig_tag_decoder trig_tag_checker u_chk (
    .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .trig_pulse(trig_pulse),
    .lk_valid(lk_valid), .seq_active(seq_active), .bcid(bcid_cnt)
);

// File: tb/sim_trig_tag_decoder.sv
module sim_trig_tag_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_valid = 1'b0;
    logic [15:0] frame_data = '0;
    logic       bx_strobe = 1'b0;
    logic       trig_pulse;
    logic [6:0] trig_xtag;
    logic [6:0] lk_xtag = '0;
    logic       lk_valid;
    logic [7:0] lk_bcid;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mem_m [128];
    bit         val_m [128];
    int         bcid_m = 0;
    bit         pend = 0;
    logic [3:0] pend_pat = '0;
    logic [4:0] pend_tag = '0;
    int         pend_k = 0;

    always #2.5 clk = ~clk;

    trig_tag_decoder u0 (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
        .bx_strobe(bx_strobe), .trig_pulse(trig_pulse), .trig_xtag(trig_xtag),
        .lk_xtag(lk_xtag), .lk_valid(lk_valid), .lk_bcid(lk_bcid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(trig_pulse == 1'b0, "R10 idle no pulse", int'(trig_pulse), 0);
        end
    endtask

    task automatic send(input logic [15:0] f);
        frame_valid = 1'b1;
        frame_data  = f;
        @(posedge clk);
        @(negedge clk);
        frame_valid = 1'b0;
        chk(trig_pulse == 1'b0, "R7 no pulse on frame cycle", int'(trig_pulse), 0);
        if (f[15:12] == 4'hB && f[11:8] != 4'h0) begin
            pend = 1; pend_pat = f[11:8]; pend_tag = f[4:0]; pend_k = 0;
        end
    endtask

    task automatic strobe(input string req);
        bit exp;
        logic [6:0] xt;
        exp = pend && pend_pat[3 - pend_k];
        xt  = {pend_tag, 2'(pend_k)};
        bx_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bx_strobe = 1'b0;
        chk(trig_pulse == exp, req, int'(trig_pulse), int'(exp));
        if (exp) begin
            chk(trig_xtag == xt, "R4 extended tag", int'(trig_xtag), int'(xt));
            mem_m[xt] = 8'(bcid_m);
            val_m[xt] = 1;
        end
        if (pend) begin
            pend_k++;
            if (pend_k == 4) pend = 0;
        end
        bcid_m = (bcid_m + 1) % 256;
        idle(2);
    endtask

    task automatic lookup(input logic [6:0] x, input string req);
        lk_xtag = x;
        @(posedge clk);
        @(negedge clk);
        chk(lk_valid == val_m[x], req, int'(lk_valid), int'(val_m[x]));
        if (val_m[x]) chk(lk_bcid == mem_m[x], req, int'(lk_bcid), int'(mem_m[x]));
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            val_m[i] = 0;
            mem_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(trig_pulse == 1'b0, "R1 reset pulse", int'(trig_pulse), 0);
        lookup(7'd0, "R1 reset entry 0");
        lookup(7'd127, "R1 reset entry 127");

        // R2 R3 R5 R6: every pattern, ignored bits set
        for (int p = 0; p < 16; p++) begin
            send({4'hB, 4'(p), 3'b101, 5'(p + 3)});
            for (int k = 0; k < 4; k++) strobe("R3 pattern sweep pulse");
        end

        // R7: wrong marker with full pattern
        send({4'h5, 4'hF, 3'b000, 5'd9});
        for (int k = 0; k < 4; k++) strobe("R7 bad marker no pulse");

        // R7: non-trigger frame in the middle of an expansion
        send({4'hB, 4'hF, 3'b000, 5'd20});
        strobe("R7 first slot");
        send({4'h3, 4'hA, 3'b111, 5'd21});
        send({4'hB, 4'h0, 3'b000, 5'd22});
        for (int k = 0; k < 3; k++) strobe("R7 slots continue");

        // R8: pre-emption by a second trigger frame
        send({4'hB, 4'hF, 3'b000, 5'd23});
        strobe("R8 old slot 0");
        strobe("R8 old slot 1");
        send({4'hB, 4'h9, 3'b000, 5'd24});
        for (int k = 0; k < 4; k++) strobe("R8 new frame restarts");

        // R9: reuse tag 4 (written earlier at slot 3)
        send({4'hB, 4'hF, 3'b000, 5'd4});
        for (int k = 0; k < 4; k++) strobe("R9 overwrite pulses");
        lookup({5'd4, 2'd3}, "R9 overwritten entry");

        // R5: wrap the crossing counter, then trigger
        for (int i = 0; i < 300; i++) strobe("R10 no pulse without frame");
        send({4'hB, 4'h6, 3'b000, 5'd30});
        for (int k = 0; k < 4; k++) strobe("R5 pulses after wrap");

        for (int x = 0; x < 128; x++) lookup(7'(x), "R6 table sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule